// File: doc/BRIEF.md
# Parity-Aided Flipped-Bit Locator

This block works on the read side of a recording channel whose writer breaks long runs of zeros by deliberately inverting one bit. A hard-decided codeword arrives one bit per accepted cycle, together with a mask bit. The mask marks the positions that a parity-check stage considers unreliable. For every position, the block estimates whether the writer inverted that bit. The estimate drives the soft-value adjuster that sits between the equalizer and the decoder.

A window of K+1 consecutive positions slides across each frame. The window ends at the position that has just arrived. A flip is declared at the window's last position in only two cases. The first is a window with all decoded bits and all mask bits at zero. The second is a window with exactly one decoded one, and a mask with exactly one one at the same offset. While a flip declared in the previous K positions is still inside the window, no new flip can be declared. These restrictions stop a cluster of unreliable bits from spreading wrong decisions. A side flag marks the case in which the single matched one is the window's last position, because the soft-value exchange rule for that bit differs. A frame ends with a last marker. Results leave in frame order after a fixed delay.

Top module: `flip_locator`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0 until an input has been accepted.
- R2: Each input accepted with in_valid=1 in cycle t yields exactly one result with out_valid=1 in cycle t+K. Results keep input order, and out_last repeats the in_last of the same position.
- R3: The first K positions of a frame (0-based positions 0..K-1) always have out_flip=0, because no complete window ends there. A frame shorter than K+1 therefore has no flips.
- R4: Position j (j>=K) gets out_flip=1 when in_bit and in_unrel were 0 at all positions j-K..j and no flip was declared at j-K..j-1.
- R5: Position j also gets out_flip=1 when exactly one position m in j-K..j-1 has in_bit=1, in_unrel is 1 exactly at m within j-K..j, in_bit=0 at j, and no flip was declared at j-K..j-1. out_special is then 0.
- R6: When the only decoded one and the only unreliable mark in the window are both at the current position j, and no flip was declared at j-K..j-1, the result has out_flip=1 and out_special=1.
- R7: A position never gets out_flip=1 if any of the preceding K positions of the same frame has out_flip=1.
- R8: A window with two or more decoded ones, or with a mask that differs from the decoded bits at any offset, gives out_flip=0. This includes a decoded one with no mark and a mark on a decoded zero.
- R9: in_last ends the frame. Windows and flip suppression do not reach across a frame boundary, so the next frame starts as in R3.
- R10: out_special=1 only occurs together with out_flip=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept the current position |
| in_bit | input | 1 | Hard-decided decoded bit |
| in_unrel | input | 1 | 1 = position flagged unreliable by parity checks |
| in_last | input | 1 | Current position is the last of its frame |
| out_valid | output | 1 | A result is presented |
| out_flip | output | 1 | 1 = the position is estimated as deliberately inverted |
| out_special | output | 1 | 1 = flip matched with the single one at the window's end |
| out_last | output | 1 | The result belongs to the frame's last position |

## Verification
The bench targets the window-edge offsets. A single one at offset K must raise the side flag. A one at an inner offset must not raise it. A design with an offset reversed would flag the wrong case, or flip where the mask and data disagree. All-zero runs check the K-position suppression: a design that checked too few previous flips would place flips too close together, and one that checked too many would skip a legal flip. Back-to-back frames check that history is cleared at in_last. A design that let state leak across the boundary would flip within the first K positions of the next frame. Idle gaps between inputs check that the latency counts cycles and that histories advance only on accepted positions.

// File: rtl/flip_locator_pkg.sv
package flip_locator_pkg;
  typedef struct packed {
    logic valid;
    logic flip;
    logic special;
    logic last;
  } loc_res_t;

  localparam int RES_W = $bits(loc_res_t);
endpackage

// File: rtl/flip_locator_hist.sv
// Per-frame history of the last K decoded bits, mask bits and flip decisions.
// Bit 0 of each history holds the most recent accepted position.
module flip_locator_hist #(
  parameter int K = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_bit,
  input  logic         in_unrel,
  input  logic         in_last,
  input  logic         flip_now,
  output logic [K-1:0] dec_hist,
  output logic [K-1:0] unr_hist,
  output logic [K-1:0] loc_hist,
  output logic         full
);
  localparam int CW = $clog2(K + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(K);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [K-1:0]  dec_d, unr_d, loc_d;

  assign full = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    dec_d = dec_hist;
    unr_d = unr_hist;
    loc_d = loc_hist;
    if (in_valid) begin
      if (in_last) begin
        cnt_d = '0;
        dec_d = '0;
        unr_d = '0;
        loc_d = '0;
      end else begin
        cnt_d = full ? cnt_q : cnt_q + CW'(1);
        dec_d = (dec_hist << 1) | K'(in_bit);
        unr_d = (unr_hist << 1) | K'(in_unrel);
        loc_d = (loc_hist << 1) | K'(flip_now);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dec_hist <= '0;
      unr_hist <= '0;
      loc_hist <= '0;
    end else if (in_valid) begin
      cnt_q    <= cnt_d;
      dec_hist <= dec_d;
      unr_hist <= unr_d;
      loc_hist <= loc_d;
    end
  end
endmodule

// File: rtl/flip_locator_match.sv
// Window pattern test. Offset l of the window maps to history distance K-l;
// offset K is the position being accepted now.
module flip_locator_match #(
  parameter int K = 7
) (
  input  logic         in_valid,
  input  logic         in_bit,
  input  logic         in_unrel,
  input  logic         full,
  input  logic [K-1:0] dec_hist,
  input  logic [K-1:0] unr_hist,
  input  logic [K-1:0] loc_hist,
  output logic         flip,
  output logic         special
);
  localparam logic [K:0] ONE = (K + 1)'(1);

  logic [K:0] win_dec, win_unr;

  for (genvar l = 0; l < K; l++) begin : g_win
    assign win_dec[l] = dec_hist[K-1-l];
    assign win_unr[l] = unr_hist[K-1-l];
  end
  assign win_dec[K] = in_bit;
  assign win_unr[K] = in_unrel;

  logic same, at_most_one, blocked;

  // Both patterns reduce to: mask equals data, and data has at most one 1.
  assign same        = (win_dec == win_unr);
  assign at_most_one = ((win_dec & (win_dec - ONE)) == '0);
  assign blocked     = |loc_hist;

  assign flip    = in_valid & full & ~blocked & same & at_most_one;
  assign special = flip & in_bit;
endmodule

// File: rtl/flip_locator_pipe.sv
// Fixed-depth delay line. The valid bit (MSB) always advances; data follow.
module flip_locator_pipe #(
  parameter int W = 4,
  parameter int D = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [D];
  logic [W-1:0] stage_d [D];

  for (genvar s = 0; s < D; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign stage_d[s] = din;
    end else begin : g_body
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign dout = stage_q[D-1];
endmodule

// File: rtl/flip_locator.sv
module flip_locator
  import flip_locator_pkg::*;
#(
  parameter int K = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_unrel,
  input  logic in_last,
  output logic out_valid,
  output logic out_flip,
  output logic out_special,
  output logic out_last
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [K-1:0] dec_hist, unr_hist, loc_hist;
  logic         full, flip_now, special_now;

  flip_locator_hist #(.K(K)) hist_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_unrel (in_unrel),
    .in_last  (in_last),
    .flip_now (flip_now),
    .dec_hist (dec_hist),
    .unr_hist (unr_hist),
    .loc_hist (loc_hist),
    .full     (full)
  );

  flip_locator_match #(.K(K)) match_i (
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_unrel (in_unrel),
    .full     (full),
    .dec_hist (dec_hist),
    .unr_hist (unr_hist),
    .loc_hist (loc_hist),
    .flip     (flip_now),
    .special  (special_now)
  );

  loc_res_t res_in, res_out;

  always_comb begin
    res_in.valid   = in_valid;
    res_in.flip    = flip_now;
    res_in.special = special_now;
    res_in.last    = in_valid & in_last;
  end

  flip_locator_pipe #(.W(RES_W), .D(K)) pipe_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (res_in),
    .dout  (res_out)
  );

  assign out_valid   = res_out.valid;
  assign out_flip    = res_out.valid & res_out.flip;
  assign out_special = res_out.valid & res_out.special;
  assign out_last    = res_out.valid & res_out.last;
endmodule

// File: rtl/flip_locator_chk.sv
module flip_locator_chk #(
  parameter int K = 7
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_last,
  input logic out_valid,
  input logic out_flip,
  input logic out_special,
  input logic out_last
);
  localparam int CW = $clog2(K + 1);
  localparam logic [CW-1:0] LIM = CW'(K);

  logic [K-1:0]  vpipe, lpipe;
  logic [CW-1:0] opos, since_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpipe      <= '0;
      lpipe      <= '0;
      opos       <= '0;
      since_flip <= LIM;
    end else begin
      vpipe <= (vpipe << 1) | K'(in_valid);
      lpipe <= (lpipe << 1) | K'(in_valid & in_last);
      if (out_valid) begin
        if (out_last) begin
          opos       <= '0;
          since_flip <= LIM;
        end else begin
          if (opos < LIM) opos <= opos + CW'(1);
          if (out_flip)              since_flip <= '0;
          else if (since_flip < LIM) since_flip <= since_flip + CW'(1);
        end
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vpipe[K-1]);                                         // R2
  AST_LAST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == lpipe[K-1]));                          // R2
  AST_NO_EARLY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && opos < LIM) |-> !out_flip);                         // R3
  AST_FLIP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && since_flip < LIM) |-> !out_flip);                   // R7
  AST_SPECIAL_NEEDS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    out_special |-> (out_flip && out_valid));                         // R10
endmodule

bind flip_locator flip_locator_chk #(.K(K)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_last     (in_last),
  .out_valid   (out_valid),
  .out_flip    (out_flip),
  .out_special (out_special),
  .out_last    (out_last)
);

// File: tb/flip_locator_tb_top.sv
`timescale 1ns/1ps
module flip_locator_tb_top;
  localparam int K    = 7;
  localparam int MAXN = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_bit, in_unrel, in_last;
  logic out_valid, out_flip, out_special, out_last;

  always #10 clk = ~clk;

  flip_locator #(.K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_unrel(in_unrel), .in_last(in_last), .out_valid(out_valid),
    .out_flip(out_flip), .out_special(out_special), .out_last(out_last)
  );

  typedef struct {
    bit    flip;
    bit    sp;
    bit    last;
    int    cyc;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   cyc      = 0;
  bit   fd [MAXN];
  bit   fu [MAXN];

  always @(posedge clk) cyc <= cyc + 1;

  // Reference: scan window ends j=K..n-1 in order, per the requirements.
  task automatic send_frame(input int n, input int gap, input string tag);
    bit q [MAXN];
    bit s [MAXN];
    for (int j = 0; j < n; j++) begin
      q[j] = 0;
      s[j] = 0;
    end
    for (int j = K; j < n; j++) begin
      bit blk = 0;
      bit ok  = 1;
      int ones = 0;
      for (int m = j - K; m < j; m++) if (q[m]) blk = 1;
      for (int m = j - K; m <= j; m++) begin
        if (fd[m] != fu[m]) ok = 0;
        if (fd[m]) ones++;
      end
      if (!blk && ok && ones <= 1) begin
        q[j] = 1;
        s[j] = fd[j];
      end
    end
    for (int j = 0; j < n; j++) begin
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = fd[j];
      in_unrel = fu[j];
      in_last  = (j == n - 1);
      e.flip = q[j];
      e.sp   = s[j];
      e.last = (j == n - 1);
      e.cyc  = cyc + K;
      e.tag  = tag;
      expq.push_back(e);
      if (gap > 0 && (j % 3) == 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_bit   = 1'b1;
          in_unrel = 1'b1;
          in_last  = 1'b1;
        end
      end
    end
  endtask

  task automatic clear_frame();
    for (int j = 0; j < MAXN; j++) begin
      fd[j] = 0;
      fu[j] = 0;
    end
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  // Monitor: compare each result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_checks++;
      if (expq.size() == 0) begin
        n_fails++;
        $display("FAIL R2: unexpected result, actual flip=%0d expected none", out_flip);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (out_flip !== e.flip || out_special !== e.sp ||
            out_last !== e.last || cyc != e.cyc) begin
          n_fails++;
          $display("FAIL %s: actual flip=%0d sp=%0d last=%0d cyc=%0d expected flip=%0d sp=%0d last=%0d cyc=%0d",
                   e.tag, out_flip, out_special, out_last, cyc,
                   e.flip, e.sp, e.last, e.cyc);
        end
      end
      if (out_special && !out_flip) begin
        n_fails++;
        $display("FAIL R10: actual special=1 flip=0 expected flip=1");
      end
    end
  end

  bit done = 0;

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_bit   = 1'b0;
    in_unrel = 1'b0;
    in_last  = 1'b0;
    repeat (4) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: actual out_valid=%0d expected 0 in reset", out_valid);
    end
    rst_n = 1'b1;
    idle(5);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: actual out_valid=%0d expected 0 after reset", out_valid);
    end

    // R4 / R7: all-zero frame, flips spaced by K+1
    clear_frame();
    send_frame(20, 0, "R4");
    clear_frame();
    send_frame(30, 2, "R7");

    // R8: unreliable mark on a decoded zero delays the flip
    clear_frame();
    fu[3] = 1;
    send_frame(16, 0, "R8");

    // R5: matched single one at an inner offset
    clear_frame();
    fd[10] = 1; fu[10] = 1;
    send_frame(24, 0, "R5");
    clear_frame();
    fd[0] = 1; fu[0] = 1;
    send_frame(12, 0, "R5");

    // R6: matched single one at the window's last offset
    clear_frame();
    fd[7] = 1; fu[7] = 1;
    send_frame(12, 0, "R6");
    clear_frame();
    fd[7] = 1;
    send_frame(12, 0, "R8");

    // R8: two matched ones in a window, and a one with no mark
    clear_frame();
    fd[9] = 1; fu[9] = 1; fd[11] = 1; fu[11] = 1; fd[20] = 1;
    send_frame(30, 0, "R8");

    // R3: short frames
    clear_frame();
    send_frame(1, 0, "R3");
    send_frame(K, 0, "R3");
    send_frame(K + 1, 0, "R3");

    // R9: back-to-back frames, state must not carry over
    clear_frame();
    send_frame(5, 0, "R9");
    send_frame(10, 0, "R9");
    send_frame(8, 0, "R9");
    send_frame(9, 1, "R9");

    // random sparse frames
    for (int f = 0; f < 40; f++) begin
      int n;
      n = 10 + int'($urandom_range(0, 60));
      for (int j = 0; j < n; j++) begin
        fd[j] = ($urandom_range(0, 7) == 0);
        fu[j] = ($urandom_range(0, 9) == 0) ? ~fd[j] : fd[j];
      end
      send_frame(n, f % 3, "R2");
    end

    idle(K + 5);
    n_checks++;
    if (expq.size() != 0) begin
      n_fails++;
      $display("FAIL R2: actual %0d results missing expected 0", expq.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule